// File: doc/BRIEF.md
# DMA Channel Transaction Sequencer

This block is the part of one DMA channel that divides a block of items into transactions and moves them one beat at a time. A block is a count of items (`block_ts`, 16 bits, up to 0xFFFF). A 3-bit burst code sets the transaction length. Code 0 gives a single-beat transaction and codes 1 to 3 give bursts of 4, 8 or 16 beats. Codes 4 to 7 are rejected. Each beat has two halves: a read request toward the channel FIFO, held until the FIFO accepts it, then a write request, held until it is accepted. The item count rises by one for each accepted write.

Software can pause the channel with `suspend`. The pause takes effect only between transactions, so any transaction already under way finishes all of its beats first. The `drained` flag tells software when the channel is stopped with nothing left in flight. After that point it is safe to abort the channel, or to clear `suspend` and continue from where it stopped. When fewer items remain than a full burst, the rest of the block is sent as single-beat transactions. Bus protocol, address generation and peripheral flow control are handled elsewhere.

Top module: `dma_txn_seq`

## Requirements
- R1: Burst code 0 gives transactions of 1 beat, code 1 gives 4 beats, code 2 gives 8 beats and code 3 gives 16 beats. `txn_burst` is high during a transaction of more than one beat and low during a single-beat transaction.
- R2: If `ch_en` rises while the burst code is 4 to 7, `cfg_err` goes high and stays high until `ch_en` falls. No read or write request is issued, and `xfer_cnt` does not change.
- R3: When fewer items remain than the burst length, each remaining item goes out as its own single-beat transaction.
- R4: A read request stays high until `rd_ack`. The write request for the same beat follows and stays high until `wr_ack`. Read and write requests are never high at the same time.
- R5: `xfer_cnt` clears when a legal block starts, rises by exactly one for each accepted write, and ends the block equal to `block_ts`.
- R6: `block_done` is a one-cycle pulse. It fires exactly once per legal block, after the last accepted write.
- R7: A `suspend` that arrives during a transaction stops the channel only after every beat of that transaction has been written.
- R8: `drained` is high only while the channel is paused between transactions. While it is high, no request is issued and `xfer_cnt` holds steady.
- R9: When `suspend` is cleared, transfer resumes with the next transaction, and the block completes with the full item count.
- R10: `txn_start` pulses once per transaction, in the first cycle of that transaction's first read request. `txn_end` pulses once per transaction, in the cycle after its last write is accepted.
- R11: A block with `block_ts` of 0 issues no requests and still gives its single `block_done` pulse.
- R12: After reset, all outputs are low and `xfer_cnt` is 0. After a block completes, the channel starts nothing new until `ch_en` has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 1 | Channel enable; starts a block when the channel is idle |
| suspend | input | 1 | Request to pause at the next transaction boundary |
| msize_code | input | 3 | Burst-length code, sampled when a block starts |
| block_ts | input | 16 | Items in the block, sampled when a block starts |
| rd_ack | input | 1 | FIFO accepts the current read beat |
| wr_ack | input | 1 | FIFO accepts the current write beat |
| rd_req | output | 1 | Read beat request |
| wr_req | output | 1 | Write beat request |
| txn_start | output | 1 | First-cycle marker of a transaction |
| txn_end | output | 1 | Marker in the cycle after a transaction's last write |
| txn_burst | output | 1 | Current transaction has more than one beat |
| drained | output | 1 | Paused at a boundary with nothing in flight |
| block_done | output | 1 | One-cycle pulse at block completion |
| cfg_err | output | 1 | Illegal burst code seen at block start |
| xfer_cnt | output | 16 | Items transferred so far in the block |

## Verification
The properties assume that `rd_ack` and `wr_ack` are acted on only while the matching request is high. They also assume that `ch_en` stays high from block start until `block_done` or `cfg_err`. The stimulus meets both assumptions. Each acknowledge is formed as the request ANDed with a gate that the bench changes on a fixed pattern, which produces stalls on both halves of a beat. `ch_en` is released only after the block has ended. `suspend` is raised only while the channel is enabled, so the boundary check sees a real transaction in progress.

// File: rtl/dts_pkg.sv
// Shared types for the DMA transaction sequencer.
// Assumes: one sequencer instance per channel; nothing here holds state.
package dts_pkg;

    // Channel sequencing states
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for enable
        S_BOUND,  // between transactions: decide next step
        S_RUN,    // beats of one transaction in progress
        S_PAUSE,  // suspended at a boundary, nothing in flight
        S_DONE,   // block finished, waiting for enable to drop
        S_FAULT   // illegal burst code, waiting for enable to drop
    } seq_state_t;

endpackage

// File: rtl/dts_msize_dec.sv
// Burst-length decoder: maps the burst code to a beat count.
// Code 0 means one beat; code i (i>0) means 2^(i+1) beats.
// Codes at or above LEGAL_CODES are flagged illegal and give length 0.
// Assumes: LEGAL_CODES is a power of two no larger than 2^CODE_W.
module dts_msize_dec #(
    parameter int CODE_W      = 3,
    parameter int LEGAL_CODES = 4,
    parameter int LEN_W       = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic [LEN_W-1:0]  len
);
    localparam int IDX_W = (LEGAL_CODES > 1) ? $clog2(LEGAL_CODES) : 1;

    logic [LEN_W-1:0] len_tab [LEGAL_CODES];

    // One table entry per legal code
    for (genvar i = 0; i < LEGAL_CODES; i++) begin : g_tab
        if (i == 0) begin : g_single
            assign len_tab[i] = LEN_W'(1);
        end else begin : g_burst
            assign len_tab[i] = LEN_W'(1) << (i + 1);
        end
    end

    // Legality check and lookup
    assign legal = ({1'b0, code} < (CODE_W+1)'(LEGAL_CODES));
    assign len   = legal ? len_tab[code[IDX_W-1:0]] : '0;

endmodule

// File: rtl/dts_beat_ctl.sv
// Beat engine: while active, runs the read half and then the write half of each beat.
// beat_done marks the cycle in which a write is accepted.
// Assumes: the acknowledges are acted on only while the matching request is high.
module dts_beat_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rd_ack,
    input  logic wr_ack,
    output logic rd_req,
    output logic wr_req,
    output logic beat_done
);
    logic wr_phase;

    // Move from the read half to the write half of a beat and back
    always_ff @(posedge clk) begin
        if (!rst_n)                     wr_phase <= 1'b0;
        else if (!active)               wr_phase <= 1'b0;
        else if (!wr_phase && rd_ack)   wr_phase <= 1'b1;
        else if (wr_phase && wr_ack)    wr_phase <= 1'b0;
    end

    // Request strobes follow the current phase
    assign rd_req    = active && !wr_phase;
    assign wr_req    = active &&  wr_phase;
    assign beat_done = wr_req && wr_ack;

endmodule

// File: rtl/dts_item_cnt.sv
// Item counter: cleared when a block starts, incremented once per accepted write.
// Assumes: clear and inc are never high in the same cycle.
module dts_item_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Running item total
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (inc)        count <= count + 1'b1;
    end

endmodule

// File: rtl/dma_txn_seq.sv
// DMA channel transaction sequencer.
// Divides a block of block_ts items into transactions of the decoded burst length.
// Once fewer items remain than a full burst, it sends the rest as single beats.
// It pauses only at transaction boundaries.
// Assumes: ch_en stays high from block start until block_done or cfg_err;
// msize_code and block_ts are sampled only when a block starts.
module dma_txn_seq #(
    parameter int CNT_W       = 16,
    parameter int CODE_W      = 3,
    parameter int LEGAL_CODES = 4,
    parameter int LEN_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              suspend,
    input  logic [CODE_W-1:0] msize_code,
    input  logic [CNT_W-1:0]  block_ts,
    input  logic              rd_ack,
    input  logic              wr_ack,
    output logic              rd_req,
    output logic              wr_req,
    output logic              txn_start,
    output logic              txn_end,
    output logic              txn_burst,
    output logic              drained,
    output logic              block_done,
    output logic              cfg_err,
    output logic [CNT_W-1:0]  xfer_cnt
);
    import dts_pkg::*;

    seq_state_t       state;
    logic [CNT_W-1:0] total_q;
    logic [LEN_W-1:0] burst_q;
    logic [LEN_W-1:0] beats_left_q;
    logic             burst_flag_q;
    logic             start_q;
    logic             end_q;
    logic             done_q;

    logic             code_ok;
    logic [LEN_W-1:0] code_len;
    logic [CNT_W-1:0] remaining;
    logic [LEN_W-1:0] next_len;
    logic             beat_done;
    logic             cnt_clear;

    dts_msize_dec #(
        .CODE_W     (CODE_W),
        .LEGAL_CODES(LEGAL_CODES),
        .LEN_W      (LEN_W)
    ) u_dec (
        .code (msize_code),
        .legal(code_ok),
        .len  (code_len)
    );

    dts_beat_ctl u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state == S_RUN),
        .rd_ack   (rd_ack),
        .wr_ack   (wr_ack),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .beat_done(beat_done)
    );

    dts_item_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .inc  (beat_done),
        .count(xfer_cnt)
    );

    // Items left in the block, and the length of the next transaction
    assign remaining = total_q - xfer_cnt;
    assign next_len  = (remaining >= CNT_W'(burst_q)) ? burst_q : LEN_W'(1);
    assign cnt_clear = (state == S_IDLE) && ch_en && code_ok;

    // Channel state machine with its registered markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            total_q      <= '0;
            burst_q      <= '0;
            beats_left_q <= '0;
            burst_flag_q <= 1'b0;
            start_q      <= 1'b0;
            end_q        <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            start_q <= 1'b0;
            end_q   <= 1'b0;
            done_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (ch_en) begin
                        if (!code_ok) begin
                            state <= S_FAULT;
                        end else begin
                            total_q <= block_ts;
                            burst_q <= code_len;
                            state   <= S_BOUND;
                        end
                    end
                end
                S_BOUND: begin
                    if (remaining == '0) begin
                        done_q <= 1'b1;
                        state  <= S_DONE;
                    end else if (suspend) begin
                        state <= S_PAUSE;
                    end else begin
                        beats_left_q <= next_len;
                        burst_flag_q <= (next_len != LEN_W'(1));
                        start_q      <= 1'b1;
                        state        <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (beat_done) begin
                        beats_left_q <= beats_left_q - 1'b1;
                        if (beats_left_q == LEN_W'(1)) begin
                            end_q        <= 1'b1;
                            burst_flag_q <= 1'b0;
                            state        <= S_BOUND;
                        end
                    end
                end
                S_PAUSE: begin
                    if (!suspend) state <= S_BOUND;
                end
                S_DONE, S_FAULT: begin
                    if (!ch_en) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Status outputs
    assign txn_start  = start_q;
    assign txn_end    = end_q;
    assign txn_burst  = burst_flag_q;
    assign block_done = done_q;
    assign drained    = (state == S_PAUSE);
    assign cfg_err    = (state == S_FAULT);

endmodule

// File: rtl/dma_txn_seq_chk.sv
// Property checker for dma_txn_seq, attached with bind.
// Assumes: acknowledges matter only while the matching request is high.
module dma_txn_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             wr_req,
    input logic             rd_ack,
    input logic             wr_ack,
    input logic             txn_start,
    input logic             txn_end,
    input logic             drained,
    input logic             block_done,
    input logic             cfg_err,
    input logic [CNT_W-1:0] xfer_cnt
);
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (xfer_cnt == $past(xfer_cnt) + 1'b1));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!rd_req && !wr_req));

    assert_drained_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (!rd_req && !wr_req));

    assert_drained_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && $past(drained)) |-> $stable(xfer_cnt));

    assert_start_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> rd_req);

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |-> (!rd_req && !wr_req));

endmodule

bind dma_txn_seq dma_txn_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .txn_start (txn_start),
    .txn_end   (txn_end),
    .drained   (drained),
    .block_done(block_done),
    .cfg_err   (cfg_err),
    .xfer_cnt  (xfer_cnt)
);

// File: tb/dma_txn_seq_test.sv
`timescale 1ns/1ps
module dma_txn_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 1'b0;
    logic        suspend = 1'b0;
    logic [2:0]  msize_code = '0;
    logic [15:0] block_ts = '0;
    logic        rd_gate = 1'b1;
    logic        wr_gate = 1'b1;
    logic        rd_ack, wr_ack;
    logic        rd_req, wr_req, txn_start, txn_end, txn_burst;
    logic        drained, block_done, cfg_err;
    logic [15:0] xfer_cnt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // observation counters for one block
    int n_txn, n_burst, n_end, n_rd, n_wr, n_done, n_overlap, n_badstart, n_drain_busy;

    always #2 clk = ~clk;   // 250 MHz

    // FIFO model: accepts a beat when its gate is open
    assign rd_ack = rd_req & rd_gate;
    assign wr_ack = wr_req & wr_gate;

    dma_txn_seq uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .suspend(suspend),
        .msize_code(msize_code), .block_ts(block_ts),
        .rd_ack(rd_ack), .wr_ack(wr_ack),
        .rd_req(rd_req), .wr_req(wr_req),
        .txn_start(txn_start), .txn_end(txn_end), .txn_burst(txn_burst),
        .drained(drained), .block_done(block_done), .cfg_err(cfg_err),
        .xfer_cnt(xfer_cnt)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [15:0] ts;
        int          txns;
        int          bursts;
        logic        err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'd5,  5,  0, 1'b0},   // R1 singles
        '{3'd1, 16'd10, 4,  2, 1'b0},   // R3 4+4+1+1
        '{3'd2, 16'd16, 2,  2, 1'b0},   // R1 8+8
        '{3'd3, 16'd20, 5,  1, 1'b0},   // R3 16+4 singles
        '{3'd3, 16'd15, 15, 0, 1'b0},   // R3 below one burst
        '{3'd4, 16'd8,  0,  0, 1'b1},   // R2 illegal
        '{3'd7, 16'd3,  0,  0, 1'b1},   // R2 illegal
        '{3'd1, 16'd0,  0,  0, 1'b0},   // R11 empty block
        '{3'd2, 16'd9,  2,  1, 1'b0}    // R3 8+1
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_txn = 0; n_burst = 0; n_end = 0; n_rd = 0; n_wr = 0;
        n_done = 0; n_overlap = 0; n_badstart = 0; n_drain_busy = 0;
    endtask

    // One cycle: move the gates at the falling edge, then sample and tally
    task automatic step();
        @(negedge clk);
        cyc++;
        rd_gate = (cyc % 3) != 0;
        wr_gate = cyc[0];
        #1;
        if (rd_req && rd_ack) n_rd++;
        if (wr_req && wr_ack) n_wr++;
        if (rd_req && wr_req) n_overlap++;
        if (txn_start) begin
            n_txn++;
            if (txn_burst) n_burst++;
            if (!rd_req) n_badstart++;
        end
        if (txn_end) n_end++;
        if (block_done) n_done++;
        if (drained && (rd_req || wr_req)) n_drain_busy++;
    endtask

    task automatic wait_end(input int limit);
        for (int k = 0; k < limit; k++) begin
            step();
            if (block_done || cfg_err) break;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] prev_cnt;
        int paused_at;
        // reset state (R12)
        repeat (3) @(negedge clk);
        #1;
        check(!rd_req && !wr_req && !txn_start && !txn_end && !txn_burst &&
              !drained && !block_done && !cfg_err, "R12 reset outputs", 1, 0);
        check(xfer_cnt == 0, "R12 reset count", xfer_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table-driven blocks
        for (int v = 0; v < NV; v++) begin
            clear_obs();
            prev_cnt   = xfer_cnt;
            msize_code = VECS[v].code;
            block_ts   = VECS[v].ts;
            ch_en      = 1'b1;
            wait_end(4000);
            if (VECS[v].err) begin
                check(cfg_err, "R2 error raised", cfg_err, 1);
                check(n_rd == 0 && n_wr == 0 && n_txn == 0, "R2 no requests", n_rd + n_wr, 0);
                check(xfer_cnt == prev_cnt, "R2 count untouched", xfer_cnt, prev_cnt);
                step();
                check(cfg_err, "R2 error held with enable", cfg_err, 1);
                ch_en = 1'b0;
                step();
                check(!cfg_err, "R2 error clears", cfg_err, 0);
            end else begin
                check(n_done == 1, "R6 done pulse", n_done, 1);
                check(xfer_cnt == VECS[v].ts, "R5 final count", xfer_cnt, VECS[v].ts);
                check(n_wr == int'(VECS[v].ts) && n_rd == n_wr, "R4 beats", n_wr, VECS[v].ts);
                check(n_txn == VECS[v].txns, "R1 R3 transaction count", n_txn, VECS[v].txns);
                check(n_burst == VECS[v].bursts, "R1 burst flag count", n_burst, VECS[v].bursts);
                check(n_end == n_txn, "R10 end markers", n_end, n_txn);
                check(n_badstart == 0, "R10 start aligned", n_badstart, 0);
                check(n_overlap == 0, "R4 no overlap", n_overlap, 0);
                if (VECS[v].ts == 0) check(n_rd == 0, "R11 no beats", n_rd, 0);
                step();
                check(!block_done, "R6 pulse one cycle", block_done, 0);
                n_rd = 0;
                repeat (5) step();
                check(n_rd == 0 && !rd_req, "R12 no restart while enabled", n_rd, 0);
                ch_en = 1'b0;
                step();
            end
        end

        // suspend in mid-burst, pause, resume (R7 R8 R9)
        clear_obs();
        msize_code = 3'd1;
        block_ts   = 16'd8;
        ch_en      = 1'b1;
        for (int k = 0; k < 200 && n_txn == 0; k++) step();
        suspend = 1'b1;
        step();
        check(!drained, "R8 not drained mid transaction", drained, 0);
        paused_at = 0;
        for (int k = 0; k < 400 && !drained; k++) step();
        check(drained, "R8 drained reached", drained, 1);
        check(xfer_cnt == 16'd4, "R7 burst finished before pause", xfer_cnt, 4);
        prev_cnt = xfer_cnt;
        n_rd = 0;
        repeat (10) step();
        check(n_rd == 0 && drained && xfer_cnt == prev_cnt, "R8 paused quiet",
              xfer_cnt, prev_cnt);
        check(n_drain_busy == 0, "R8 drained only when idle", n_drain_busy, 0);
        suspend = 1'b0;
        wait_end(400);
        check(xfer_cnt == 16'd8 && n_done == 1, "R9 resumed to completion", xfer_cnt, 8);
        check(n_txn == 2 && !drained, "R9 transactions after resume", n_txn, 2);
        ch_en = 1'b0;
        repeat (2) step();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule